// File: doc/BRIEF.md
# Serial-Loaded Sound Chip Write Sequencer

This block performs register writes into a sound synthesis chip whose address and data pins are fed by two cascaded serial-to-parallel shift registers with output latches. A caller presents a 5-bit register address and an 8-bit value with a one-cycle request. The block then shifts sixteen bits out on a serial data line and a shift clock, and pulses the latch clock to move the bits onto the chip pins. After a set gap it drives the chip select and write enable low for a minimum time, raises them again and signals completion.

All timing is counted in system clock cycles. The shift clock half-period, the latch pulse width and the latch-to-select gap are given directly as cycle counts. The select pulse length is derived from a minimum time in nanoseconds and the system clock period in picoseconds, rounded up. Two parameters choose the bit order within each byte and which of the two shift registers sits next to the serial output. This allows any of the four board wirings to be driven correctly.

Top module: `sndchip_wr_seq`

## Requirements
- R1: While reset is low, and in the first cycle after reset is applied during a write, `cs_n` and `we_n` are 1, `sck`, `rck`, `busy` and `done` are 0, and the interrupted write never reaches the chip.
- R2: A request seen in a cycle where `busy` is 0 is accepted: `busy` reads 1 from the next cycle on and returns to 0 in the same cycle that `cs_n` returns high. `done` is 1 for exactly that one cycle.
- R3: A request raised while `busy` is 1 has no effect: the write in progress delivers its own address and data, and no further select pulse follows it.
- R4: Each write produces exactly 16 rising edges of `sck`. `sck` stays high for `SCK_HALF` cycles per pulse. `sdo` changes only while `sck` is low, never in the same cycle as `sck`, and is held for at least `SCK_HALF` cycles before each rising `sck` edge.
- R5: Shift order: the byte for the register farther from the serial output goes first. The address byte is `{3'b000, addr}`. With `ADDR_NEAR`=1 (default) the data byte goes first; with 0 the address byte goes first. With `MSB_FIRST`=1 (default) each byte is sent bit 7 first; with 0 it is sent bit 0 first.
- R6: `rck` rises one cycle after the final falling edge of `sck` and stays high for `LATCH_W` cycles.
- R7: `cs_n` falls exactly `LATCH_W + GAP_CYC` cycles after `rck` rises.
- R8: `cs_n` stays low for ceil(`SEL_MIN_NS`*1000/`CLK_PS`) cycles. That is 150 cycles for the default 1200 ns at 8000 ps, and 172 cycles for 1200 ns at 7000 ps.
- R9: `cs_n` is 1 in every cycle where `sck` or `rck` is 1.
- R10: `we_n` equals `cs_n` in every cycle.
- R11: When `cs_n` falls, the latched shift register outputs decode to the requested address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Write request, sampled when idle |
| addr | input | ADDR_W | Chip register address |
| data | input | DATA_W | Value to write |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when the write finishes |
| sdo | output | 1 | Serial data to the shift register chain |
| sck | output | 1 | Shift clock, data taken on the rising edge |
| rck | output | 1 | Latch clock, outputs updated on the rising edge |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The hardest situation to reach from the ports is a request arriving in the middle of a write. A wrongly accepted request would show only as a corrupted frame or as a spurious extra select pulse long after the fact. The stimulus therefore raises requests carrying different values both during shifting and during the select pulse. The scoreboard rejects any select pulse it has no queued entry for. A reset is also asserted mid-shift to prove that the partial frame never produces a select. Two instances, wired for opposite bit and chain orders and with different timing, run the same stimulus through bench models of the shift register chain.

// File: rtl/sndchip_wr_seq.sv
module sndchip_wr_seq #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int SR_W       = 8,
  parameter int SCK_HALF   = 2,
  parameter int LATCH_W    = 2,
  parameter int GAP_CYC    = 2,
  parameter int CLK_PS     = 8000,
  parameter int SEL_MIN_NS = 1200,
  parameter bit MSB_FIRST  = 1'b1,
  parameter bit ADDR_NEAR  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              done,
  output logic              sdo,
  output logic              sck,
  output logic              rck,
  output logic              cs_n,
  output logic              we_n
);

  localparam int FRAME_W = 2 * SR_W;
  localparam int SEL_CYC = (SEL_MIN_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int MAX_A   = (SCK_HALF > LATCH_W) ? SCK_HALF : LATCH_W;
  localparam int MAX_B   = (GAP_CYC > SEL_CYC) ? GAP_CYC : SEL_CYC;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(FRAME_W + 1);
  localparam int LW      = $clog2(SEL_CYC + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_DRV, S_LO, S_HI, S_RCK, S_LAT, S_GAP, S_SEL
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     nbits;
  logic [FRAME_W-1:0] shreg;

  logic [SR_W-1:0] a_byte, d_byte, a_rev, d_rev, a_ord, d_ord;
  logic [FRAME_W-1:0] frame;

  assign a_byte = {{(SR_W-ADDR_W){1'b0}}, addr};
  assign d_byte = {{(SR_W-DATA_W){1'b0}}, data};

  for (genvar i = 0; i < SR_W; i++) begin : g_rev
    assign a_rev[i] = a_byte[SR_W-1-i];
    assign d_rev[i] = d_byte[SR_W-1-i];
  end

  assign a_ord = MSB_FIRST ? a_byte : a_rev;
  assign d_ord = MSB_FIRST ? d_byte : d_rev;
  assign frame = ADDR_NEAR ? {d_ord, a_ord} : {a_ord, d_ord};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      nbits <= '0;
      shreg <= '0;
      sdo   <= 1'b0;
      sck   <= 1'b0;
      rck   <= 1'b0;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          shreg <= frame;
          nbits <= '0;
          st    <= S_DRV;
        end
        S_DRV: begin
          sdo   <= shreg[FRAME_W-1];
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
          cnt   <= '0;
          st    <= S_LO;
        end
        S_LO: if (cnt == CW'(SCK_HALF-1)) begin
          sck <= 1'b1;
          cnt <= '0;
          st  <= S_HI;
        end else cnt <= cnt + 1'b1;
        S_HI: if (cnt == CW'(SCK_HALF-1)) begin
          sck   <= 1'b0;
          cnt   <= '0;
          nbits <= nbits + 1'b1;
          st    <= (nbits == BW'(FRAME_W-1)) ? S_RCK : S_DRV;
        end else cnt <= cnt + 1'b1;
        S_RCK: begin
          rck <= 1'b1;
          cnt <= '0;
          st  <= S_LAT;
        end
        S_LAT: if (cnt == CW'(LATCH_W-1)) begin
          rck <= 1'b0;
          cnt <= '0;
          st  <= S_GAP;
        end else cnt <= cnt + 1'b1;
        S_GAP: if (cnt == CW'(GAP_CYC-1)) begin
          cs_n <= 1'b0;
          we_n <= 1'b0;
          cnt  <= '0;
          st   <= S_SEL;
        end else cnt <= cnt + 1'b1;
        S_SEL: if (cnt == CW'(SEL_CYC-1)) begin
          cs_n <= 1'b1;
          we_n <= 1'b1;
          done <= 1'b1;
          st   <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [LW-1:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_len <= '0;
    else if (!cs_n) low_len <= low_len + 1'b1;
    else            low_len <= '0;
  end

  // R9
  cs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck || rck) |-> cs_n);

  // R4
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($stable(sck) && !sck));

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(sdo));

  // R10
  we_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_n == cs_n);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $rose(cs_n)));

  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  // R8
  sel_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (low_len == LW'(SEL_CYC)));

endmodule

// File: tb/sim_sndchip_wr_seq.sv
module sr_chain_model #(
  parameter bit MSB_FIRST = 1'b1,
  parameter bit ADDR_NEAR = 1'b1
) (
  input  logic       sdo,
  input  logic       sck,
  input  logic       rck,
  output logic [4:0] a_pins,
  output logic [7:0] d_pins
);
  logic [7:0] near_sr = '0, far_sr = '0, near_q = '0, far_q = '0;
  logic [7:0] a_reg, d_reg, a_flip, d_flip;

  always @(posedge sck) begin
    near_sr <= {near_sr[6:0], sdo};
    far_sr  <= {far_sr[6:0], near_sr[7]};
  end
  always @(posedge rck) begin
    near_q <= near_sr;
    far_q  <= far_sr;
  end

  assign a_reg = ADDR_NEAR ? near_q : far_q;
  assign d_reg = ADDR_NEAR ? far_q : near_q;
  always_comb
    for (int k = 0; k < 8; k++) begin
      a_flip[k] = a_reg[7-k];
      d_flip[k] = d_reg[7-k];
    end
  assign a_pins = MSB_FIRST ? a_reg[4:0] : a_flip[4:0];
  assign d_pins = MSB_FIRST ? d_reg : d_flip;
endmodule

module sim_sndchip_wr_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] data = '0;
  logic [1:0] busy, done, sdo, sck, rck, cs_n, we_n;
  logic [1:0][4:0] pa;
  logic [1:0][7:0] pd;

  sndchip_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .data(data),
    .busy(busy[0]), .done(done[0]), .sdo(sdo[0]), .sck(sck[0]),
    .rck(rck[0]), .cs_n(cs_n[0]), .we_n(we_n[0]));

  sndchip_wr_seq #(
    .SCK_HALF(1), .LATCH_W(1), .GAP_CYC(4), .CLK_PS(7000),
    .MSB_FIRST(1'b0), .ADDR_NEAR(1'b0)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .data(data),
    .busy(busy[1]), .done(done[1]), .sdo(sdo[1]), .sck(sck[1]),
    .rck(rck[1]), .cs_n(cs_n[1]), .we_n(we_n[1]));

  sr_chain_model m0 (.sdo(sdo[0]), .sck(sck[0]), .rck(rck[0]),
                     .a_pins(pa[0]), .d_pins(pd[0]));
  sr_chain_model #(.MSB_FIRST(1'b0), .ADDR_NEAR(1'b0)) m1 (
    .sdo(sdo[1]), .sck(sck[1]), .rck(rck[1]), .a_pins(pa[1]), .d_pins(pd[1]));

  int SCKH [2] = '{2, 1};
  int LATW [2] = '{2, 1};
  int GAPC [2] = '{2, 4};
  int SELC [2] = '{150, 172};

  int n_chk = 0, n_fail = 0;
  logic [12:0] q0[$], q1[$];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  int cyc = 0;
  int sdo_t[2], sck_up_t[2], sck_dn_t[2], rck_t[2], cs_t[2], nrise[2];
  bit bad_edge[2], bad_cs[2], bad_we[2], bad_done[2];
  logic p_sdo[2], p_sck[2], p_rck[2], p_cs[2];

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        nrise[i] = 0; bad_edge[i] = 0; bad_cs[i] = 0; bad_we[i] = 0; bad_done[i] = 0;
        sdo_t[i] = -100; sck_up_t[i] = 0; sck_dn_t[i] = 0; rck_t[i] = 0; cs_t[i] = 0;
      end else begin
        if (sdo[i] !== p_sdo[i]) begin
          sdo_t[i] = cyc;
          if (sck[i] || (sck[i] !== p_sck[i])) bad_edge[i] = 1;
        end
        if (sck[i] && !p_sck[i]) begin
          nrise[i]++;
          sck_up_t[i] = cyc;
          if (cyc - sdo_t[i] < SCKH[i]) bad_edge[i] = 1;
        end
        if (!sck[i] && p_sck[i]) begin
          sck_dn_t[i] = cyc;
          if (cyc - sck_up_t[i] != SCKH[i]) bad_edge[i] = 1;
        end
        if (rck[i] && !p_rck[i]) begin
          rck_t[i] = cyc;
          check(cyc - sck_dn_t[i] == 1, "R6 rck after last sck", cyc - sck_dn_t[i], 1);
        end
        if (!rck[i] && p_rck[i])
          check(cyc - rck_t[i] == LATW[i], "R6 rck width", cyc - rck_t[i], LATW[i]);
        if ((sck[i] || rck[i]) && !cs_n[i]) bad_cs[i] = 1;
        if (we_n[i] !== cs_n[i]) bad_we[i] = 1;
        if (done[i] && !(cs_n[i] && !p_cs[i] && !busy[i])) bad_done[i] = 1;
        if (!cs_n[i] && p_cs[i]) begin
          logic [12:0] e;
          cs_t[i] = cyc;
          check(cyc - rck_t[i] == LATW[i] + GAPC[i], "R7 latch-to-select",
                cyc - rck_t[i], LATW[i] + GAPC[i]);
          check(nrise[i] == 16, "R4 sck edges", nrise[i], 16);
          nrise[i] = 0;
          if (((i == 0) ? q0.size() : q1.size()) == 0) begin
            check(1'b0, "R3 unexpected select pulse", 1, 0);
          end else begin
            e = (i == 0) ? q0.pop_front() : q1.pop_front();
            check(pa[i] == e[12:8], "R5 R11 address at pins", pa[i], e[12:8]);
            check(pd[i] == e[7:0], "R5 R11 data at pins", pd[i], e[7:0]);
          end
        end
        if (cs_n[i] && !p_cs[i]) begin
          check(cyc - cs_t[i] == SELC[i], "R8 select width", cyc - cs_t[i], SELC[i]);
          check(done[i] && !busy[i], "R2 done with busy low", {done[i], busy[i]}, 2);
          check(!bad_edge[i], "R4 sdo/sck ordering", bad_edge[i], 0);
          check(!bad_cs[i], "R9 select during shift", bad_cs[i], 0);
          check(!bad_we[i], "R10 we_n tracks cs_n", bad_we[i], 0);
          check(!bad_done[i], "R2 stray done", bad_done[i], 0);
          bad_edge[i] = 0; bad_cs[i] = 0; bad_we[i] = 0; bad_done[i] = 0;
        end
      end
      p_sdo[i] = sdo[i]; p_sck[i] = sck[i]; p_rck[i] = rck[i]; p_cs[i] = cs_n[i];
    end
  end

  task automatic send(input logic [4:0] a, input logic [7:0] d, input bit expect_take);
    @(negedge clk);
    addr = a; data = d; req = 1'b1;
    if (expect_take) begin
      q0.push_back({a, d});
      q1.push_back({a, d});
    end
    @(negedge clk);
    req = 1'b0;
    if (expect_take)
      check(busy == 2'b11, "R2 busy after accept", busy, 3);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy != 2'b00);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle_outputs(input string tag);
    check(cs_n == 2'b11 && we_n == 2'b11, {tag, " select idle"}, {cs_n, we_n}, 15);
    check(sck == 2'b00 && rck == 2'b00, {tag, " clocks idle"}, {sck, rck}, 0);
    check(busy == 2'b00 && done == 2'b00, {tag, " busy/done idle"}, {busy, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle_outputs("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(5'h00, 8'h00, 1'b1); wait_idle();
    send(5'h1F, 8'hFF, 1'b1); wait_idle();
    send(5'h01, 8'h80, 1'b1); wait_idle();
    send(5'h10, 8'h01, 1'b1); wait_idle();

    // R3: requests during shifting and during the select pulse
    send(5'h15, 8'hA5, 1'b1);
    repeat (20) @(negedge clk);
    send(5'h0A, 8'h5A, 1'b0);
    repeat (80) @(negedge clk);
    send(5'h0A, 8'h5A, 1'b0);
    wait_idle();
    repeat (10) @(negedge clk);
    check(busy == 2'b00, "R3 no restart after ignored request", busy, 0);
    check(q0.size() == 0 && q1.size() == 0, "R3 queue drained",
          q0.size() + q1.size(), 0);

    for (int k = 0; k < 6; k++) begin
      send(5'(k * 7 + 3), 8'(k * 37 + 11), 1'b1);
      wait_idle();
    end

    // R1: reset in the middle of shifting
    send(5'h03, 8'h3C, 1'b1);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 mid-write reset");
    q0.delete(); q1.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check(cs_n == 2'b11 && busy == 2'b00, "R1 aborted write never selects",
          {cs_n, busy}, 12);

    send(5'h0C, 8'hC3, 1'b1); wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule